// File: doc/BRIEF.md
# Four-Plane Tile Colour Charger

This block sits between a CPU bus and a bitmap store made of four parallel bit planes. The store holds one 16-bit word per address in each plane. With the unit switched off, every bus access reaches exactly one plane, the one named by the plane select. With the unit switched on, one bus access acts on every participating plane at once. A write either stamps each plane's colour pattern into memory or merges that pattern under a pixel mask carried on the data bus. A read either returns a mask of the pixels whose participating planes all equal the programmed colour or, in merge mode, returns zero.

Four 8-bit pattern registers, one per plane, are loaded through a dedicated register port. A mode register sets the enable, the write flavour and the plane exclusion mask. The plane memories are internal single-port synchronous RAMs. A merge write needs a read cycle before its write cycle, and `busy` marks that extra cycle.

Top module: `plane_color_charger`

## Requirements
- R1: After reset `busy` and `bus_rvalid` are 0 and the mode register is all zero, so the unit starts switched off.
- R2: With the unit off (mode bit 7 = 0), a write changes only the plane named by `bus_plane`, and a read returns that plane's word.
- R3: Mode byte layout: bit 7 switches the unit on, bit 6 selects merge (1) or stamp (0), and bits 3:0 exclude planes 3..0, where a 0 bit lets the plane take part. Bits 5:4 have no effect.
- R4: Stamp write (mode bits 7,6 = 1,0): in each participating plane, every enabled byte lane is replaced by that plane's pattern byte and the bus data has no effect. Excluded planes keep their contents.
- R5: Merge write (mode bits 7,6 = 1,1): each participating plane's enabled lanes become (old AND NOT data) OR (pattern AND data). Excluded planes keep their contents.
- R6: Compare read (mode bits 7,6 = 1,0) returns NOT of the OR over participating planes of (plane word XOR {pattern, pattern}). With every plane excluded the result is all ones.
- R7: A read with the unit on in merge mode returns 0 with `bus_rvalid` high.
- R8: Byte lane 0 is bits 7:0 and lane 1 is bits 15:8. A write never changes a lane whose `bus_be` bit is 0, and read data is 0 in every lane whose `bus_be` bit was 0.
- R9: Read data and `bus_rvalid` appear in the cycle after the accepted request. A merge write holds `busy` high for exactly one cycle after acceptance, and a request presented while `busy` is high is ignored.
- R10: A pulse on `tile_we` loads `tile_wdata` into the pattern register of the plane picked by `tile_sel`, and leaves the other three patterns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load the mode register |
| mode_wdata | input | 8 | New mode byte |
| tile_we | input | 1 | Load one pattern register |
| tile_sel | input | 2 | Pattern register index (plane number) |
| tile_wdata | input | 8 | New pattern byte |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_plane | input | 2 | Plane addressed while the unit is off |
| bus_addr | input | ADDR_W | Word address in each plane |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data, or pixel mask in merge mode |
| bus_rdata | output | 16 | Read data or compare mask |
| bus_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Merge write completing; requests ignored |

## Verification
The plane contents are seeded through the pass-through path with a different word per plane. The stamp, merge and compare operations are then run over those words, and the results are read back one plane at a time. Stamp writes use a bus data value unrelated to the patterns, so a design that leaks the data is caught. They exclude one plane, so a design that ignores the exclusion mask is caught. Merge writes use a mask with mixed bits, so swapped old and pattern terms show up. One merge write drives a full mask on a single lane, which checks the lane gating. The compare patterns are chosen so that one plane mismatches in only one byte. Excluding that plane flips the result, and a separate case with only one plane taking part shows the XOR polarity.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int NPLANES = 4;
  localparam int PAT_W   = 8;

  typedef struct packed {
    logic               enable;
    logic               rmw;
    logic [NPLANES-1:0] plane_off;
  } mode_t;

  typedef enum logic [1:0] {
    RK_PASS = 2'd0,
    RK_CMP  = 2'd1,
    RK_ZERO = 2'd2
  } rkind_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_RMW_WR = 1'b1
  } state_t;

  function automatic mode_t decode_mode(input logic [7:0] v);
    mode_t m;
    m.enable    = v[7];
    m.rmw       = v[6];
    m.plane_off = v[3:0];
    return m;
  endfunction

endpackage

// File: rtl/pcc_cfg_regs.sv
module pcc_cfg_regs
  import pcc_pkg::*;
#(
  parameter int SEL_W = $clog2(NPLANES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_we,
  input  logic [7:0]                    mode_wdata,
  input  logic                          tile_we,
  input  logic [SEL_W-1:0]              tile_sel,
  input  logic [PAT_W-1:0]              tile_wdata,
  output mode_t                         mode,
  output logic [NPLANES-1:0][PAT_W-1:0] tiles
);

  mode_t                         mode_q, mode_d;
  logic [NPLANES-1:0][PAT_W-1:0] tile_q, tile_d;
  logic                          unused_mode_bits;

  assign unused_mode_bits = ^mode_wdata[5:4];

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = decode_mode(mode_wdata);
  end

  always_comb begin
    tile_d = tile_q;
    for (int p = 0; p < NPLANES; p++) begin
      if (tile_we && (tile_sel == SEL_W'(p))) tile_d[p] = tile_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tile_q <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (tile_we) tile_q <= tile_d;
    end
  end

  assign mode  = mode_q;
  assign tiles = tile_q;

  a_r10_tile_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tile_we |=> $stable(tiles));

  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode));

endmodule

// File: rtl/pcc_plane_ram.sv
module pcc_plane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      for (int l = 0; l < LANES; l++) begin
        if (we && be[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = PAT_W * LANES,
  localparam int SEL_W  = $clog2(NPLANES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  mode_t                          mode,
  input  logic [NPLANES-1:0][PAT_W-1:0]  tiles,
  input  logic                           bus_req,
  input  logic                           bus_we,
  input  logic [SEL_W-1:0]               bus_plane,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [LANES-1:0]               bus_be,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic                           bus_rvalid,
  output logic                           busy,
  output logic [NPLANES-1:0]             ram_en,
  output logic [NPLANES-1:0]             ram_we,
  output logic [ADDR_W-1:0]              ram_addr,
  output logic [LANES-1:0]               ram_be,
  output logic [NPLANES-1:0][DATA_W-1:0] ram_wdata,
  input  logic [NPLANES-1:0][DATA_W-1:0] ram_q
);

  state_t              st_q, st_d;
  rkind_t              kind_q, kind_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    be_q;
  logic [DATA_W-1:0]   data_q;
  logic [NPLANES-1:0]  on_q, on_d;
  logic [SEL_W-1:0]    plane_q;
  logic                rvalid_q, rvalid_d;
  logic                accept;
  logic [NPLANES-1:0][DATA_W-1:0] tile_word;
  logic [DATA_W-1:0]   lane_mask;
  logic [DATA_W-1:0]   mismatch;
  logic [DATA_W-1:0]   rd_raw;

  genvar gp, gl;
  generate
    for (gp = 0; gp < NPLANES; gp++) begin : g_tw
      assign tile_word[gp] = {LANES{tiles[gp]}};
    end
    for (gl = 0; gl < LANES; gl++) begin : g_lm
      assign lane_mask[gl*PAT_W +: PAT_W] = {PAT_W{be_q[gl]}};
    end
  endgenerate

  assign accept = bus_req && (st_q == ST_IDLE);
  assign on_d   = ~mode.plane_off;
  assign busy   = (st_q == ST_RMW_WR);

  // next state and memory port drive
  always_comb begin
    st_d      = st_q;
    kind_d    = kind_q;
    rvalid_d  = 1'b0;
    ram_en    = '0;
    ram_we    = '0;
    ram_addr  = bus_addr;
    ram_be    = bus_be;
    ram_wdata = '0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          rvalid_d = !bus_we;
          if (!mode.enable) begin
            if (bus_we) begin
              ram_en[bus_plane]    = 1'b1;
              ram_we[bus_plane]    = 1'b1;
              ram_wdata[bus_plane] = bus_wdata;
            end else begin
              ram_en = '1;
              kind_d = RK_PASS;
            end
          end else if (bus_we && !mode.rmw) begin
            for (int p = 0; p < NPLANES; p++) begin
              ram_en[p]    = on_d[p];
              ram_we[p]    = on_d[p];
              ram_wdata[p] = tile_word[p];
            end
          end else if (bus_we) begin
            ram_en = '1;
            st_d   = ST_RMW_WR;
          end else begin
            ram_en = '1;
            kind_d = mode.rmw ? RK_ZERO : RK_CMP;
          end
        end
      end
      ST_RMW_WR: begin
        ram_addr = addr_q;
        ram_be   = be_q;
        for (int p = 0; p < NPLANES; p++) begin
          ram_en[p]    = on_q[p];
          ram_we[p]    = on_q[p];
          ram_wdata[p] = (ram_q[p] & ~data_q) | (tile_word[p] & data_q);
        end
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= RK_PASS;
      rvalid_q <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      data_q   <= '0;
      on_q     <= '0;
      plane_q  <= '0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= rvalid_d;
      if (accept) begin
        kind_q  <= kind_d;
        addr_q  <= bus_addr;
        be_q    <= bus_be;
        data_q  <= bus_wdata;
        on_q    <= on_d;
        plane_q <= bus_plane;
      end
    end
  end

  // read result
  always_comb begin
    mismatch = '0;
    for (int p = 0; p < NPLANES; p++) begin
      if (on_q[p]) mismatch = mismatch | (ram_q[p] ^ tile_word[p]);
    end
    case (kind_q)
      RK_PASS: rd_raw = ram_q[plane_q];
      RK_CMP:  rd_raw = ~mismatch;
      default: rd_raw = '0;
    endcase
  end

  assign bus_rdata  = rvalid_q ? (rd_raw & lane_mask) : '0;
  assign bus_rvalid = rvalid_q;

  a_r9_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r9_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && !bus_we) |=> bus_rvalid);

  a_r7_rmw_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && !bus_we && mode.enable && mode.rmw) |=> (bus_rdata == '0));

  a_r2_single_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && bus_we && !mode.enable) |-> ($countones(ram_we) == 1));

  a_r5_read_phase_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && bus_we && mode.enable && mode.rmw) |-> (ram_we == '0));

endmodule

// File: rtl/plane_color_charger.sv
module plane_color_charger
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = PAT_W * LANES,
  localparam int SEL_W  = $clog2(NPLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [7:0]        mode_wdata,
  input  logic              tile_we,
  input  logic [SEL_W-1:0]  tile_sel,
  input  logic [PAT_W-1:0]  tile_wdata,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [SEL_W-1:0]  bus_plane,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              busy
);

  mode_t                          mode;
  logic [NPLANES-1:0][PAT_W-1:0]  tiles;
  logic [NPLANES-1:0]             ram_en, ram_we;
  logic [ADDR_W-1:0]              ram_addr;
  logic [LANES-1:0]               ram_be;
  logic [NPLANES-1:0][DATA_W-1:0] ram_wdata, ram_q;

  pcc_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tile_we(tile_we), .tile_sel(tile_sel), .tile_wdata(tile_wdata),
    .mode(mode), .tiles(tiles)
  );

  pcc_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode(mode), .tiles(tiles),
    .bus_req(bus_req), .bus_we(bus_we), .bus_plane(bus_plane),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_q(ram_q)
  );

  genvar gp;
  generate
    for (gp = 0; gp < NPLANES; gp++) begin : g_plane
      pcc_plane_ram #(.ADDR_W(ADDR_W), .LANE_W(PAT_W), .LANES(LANES)) u_ram (
        .clk(clk), .en(ram_en[gp]), .we(ram_we[gp]), .addr(ram_addr),
        .be(ram_be), .wdata(ram_wdata[gp]), .q(ram_q[gp])
      );
    end
  endgenerate

endmodule

// File: tb/plane_color_charger_tb.sv
module plane_color_charger_tb;

  logic        clk, rst_n;
  logic        mode_we, tile_we, bus_req, bus_we;
  logic [7:0]  mode_wdata, tile_wdata;
  logic [1:0]  tile_sel, bus_plane, bus_be;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  plane_color_charger u_dut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tile_we(tile_we), .tile_sel(tile_sel), .tile_wdata(tile_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_plane(bus_plane),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    mode_we = 1; mode_wdata = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic set_tile(input logic [1:0] i, input logic [7:0] v);
    tile_we = 1; tile_sel = i; tile_wdata = v;
    @(negedge clk); tile_we = 0;
  endtask

  task automatic bwr(input logic [1:0] pl, input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_req = 1; bus_we = 1; bus_plane = pl; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk); bus_req = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic brd(input logic [1:0] pl, input logic [7:0] a, input logic [1:0] be,
                     output logic [15:0] d, output logic v);
    bus_req = 1; bus_we = 0; bus_plane = pl; bus_addr = a; bus_be = be; bus_wdata = 16'h0;
    @(negedge clk); bus_req = 0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic seed(input logic [7:0] a, input logic [15:0] w0, input logic [15:0] w1,
                      input logic [15:0] w2, input logic [15:0] w3);
    set_mode(8'h00);
    bwr(0, a, 2'b11, w0); bwr(1, a, 2'b11, w1);
    bwr(2, a, 2'b11, w2); bwr(3, a, 2'b11, w3);
  endtask

  task automatic expect_planes(input string tag, input logic [7:0] a, input logic [15:0] e0,
                               input logic [15:0] e1, input logic [15:0] e2, input logic [15:0] e3);
    logic [15:0] d; logic v;
    set_mode(8'h00);
    brd(0, a, 2'b11, d, v); chk({tag, " p0"}, d, e0);
    brd(1, a, 2'b11, d, v); chk({tag, " p1"}, d, e1);
    brd(2, a, 2'b11, d, v); chk({tag, " p2"}, d, e2);
    brd(3, a, 2'b11, d, v); chk({tag, " p3"}, d, e3);
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", {15'h0, busy}, 16'h0);
    chk("R1 rvalid after reset", {15'h0, bus_rvalid}, 16'h0);
  endtask

  task automatic t_pass;
    logic [15:0] d; logic v;
    // R1: no mode write yet, so accesses must pass straight through
    bwr(2, 8'd5, 2'b11, 16'hCAFE);
    brd(2, 8'd5, 2'b11, d, v);
    chk("R1 R2 pass-through after reset", d, 16'hCAFE);
    chk("R9 rvalid one cycle after read", {15'h0, v}, 16'h1);
    seed(8'd5, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
    expect_planes("R2 pass-through planes", 8'd5, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
    bwr(2, 8'd5, 2'b01, 16'hAAAA);
    brd(2, 8'd5, 2'b11, d, v);
    chk("R8 low-lane write", d, 16'h03AA);
    brd(2, 8'd5, 2'b10, d, v);
    chk("R8 read lane gating", d, 16'h0300);
  endtask

  task automatic t_tdw;
    set_tile(0, 8'h11); set_tile(1, 8'h22); set_tile(2, 8'h33); set_tile(3, 8'h44);
    seed(8'd10, 16'hA0A0, 16'hB1B1, 16'hC2C2, 16'hD3D3);
    seed(8'd11, 16'hA0A0, 16'hB1B1, 16'hC2C2, 16'hD3D3);
    set_mode(8'hB2);   // R3: bits 5:4 set without effect, plane 1 excluded
    bwr(0, 8'd10, 2'b11, 16'h1234);
    expect_planes("R4 R3 R10 stamp excl p1", 8'd10, 16'h1111, 16'hB1B1, 16'h3333, 16'h4444);
    set_mode(8'h80);
    bwr(0, 8'd11, 2'b10, 16'hFFFF);
    expect_planes("R4 R8 stamp high lane", 8'd11, 16'h11A0, 16'h22B1, 16'h33C2, 16'h44D3);
  endtask

  task automatic t_rmw;
    logic [15:0] d; logic v;
    seed(8'd20, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    seed(8'd21, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    seed(8'd22, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    set_mode(8'hC8);
    bus_req = 1; bus_we = 1; bus_plane = 0; bus_addr = 8'd20; bus_be = 2'b11; bus_wdata = 16'h0FF0;
    @(negedge clk);
    chk("R9 busy after merge accept", {15'h0, busy}, 16'h1);
    bus_addr = 8'd21; bus_wdata = 16'hFFFF;   // presented while busy: ignored
    @(negedge clk); bus_req = 0;
    chk("R9 busy single cycle", {15'h0, busy}, 16'h0);
    expect_planes("R5 merge excl p3", 8'd20, 16'h1114, 16'h5228, 16'h933C, 16'hDEF0);
    expect_planes("R9 ignored while busy", 8'd21, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    set_mode(8'hC0);
    bwr(0, 8'd22, 2'b01, 16'hFFFF);
    expect_planes("R5 R8 merge low lane", 8'd22, 16'h1211, 16'h5622, 16'h9A33, 16'hDE44);
    set_mode(8'hC0);
    brd(0, 8'd22, 2'b11, d, v);
    chk("R7 merge-mode read zero", d, 16'h0000);
    chk("R7 merge-mode read valid", {15'h0, v}, 16'h1);
  endtask

  task automatic t_cmp;
    logic [15:0] d; logic v;
    set_tile(0, 8'hFF); set_tile(1, 8'h00); set_tile(2, 8'hF0); set_tile(3, 8'h0F);
    seed(8'd30, 16'hFFFF, 16'h00FF, 16'hF0F0, 16'h0F0F);
    set_mode(8'h80);
    brd(0, 8'd30, 2'b11, d, v); chk("R6 compare all planes", d, 16'hFF00);
    set_mode(8'h82);
    brd(0, 8'd30, 2'b11, d, v); chk("R6 R3 compare excl p1", d, 16'hFFFF);
    set_mode(8'h8F);
    brd(0, 8'd30, 2'b11, d, v); chk("R6 compare none enabled", d, 16'hFFFF);
    set_tile(0, 8'h0F);
    set_mode(8'h8E);
    brd(0, 8'd30, 2'b11, d, v); chk("R6 compare only p0", d, 16'h0F0F);
    brd(0, 8'd30, 2'b01, d, v); chk("R6 R8 compare low lane", d, 16'h000F);
  endtask

  initial begin
    rst_n = 0; mode_we = 0; tile_we = 0; bus_req = 0; bus_we = 0;
    mode_wdata = 0; tile_wdata = 0; tile_sel = 0; bus_plane = 0;
    bus_addr = 0; bus_be = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_tdw();
    t_rmw();
    t_cmp();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule